// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Generator

This block turns one request to store part of a register into a single aligned write on a 32-bit big-endian memory bus. The request carries a byte address, a 32-bit source value and a mode bit. In begin mode the block writes the low-order bytes of the source, from the addressed byte to the end of the word. In end mode it writes the high-order bytes of the source into the bytes that come before the addressed byte in the same word. Together the two modes let software store a string of bytes whose ends are not word aligned.

The low two address bits choose the lanes. The whole update goes out as one write with a word-aligned address, a byte-enable mask and the data already placed on its lanes. A three-byte store is therefore a single bus beat and cannot be split. An end-mode request whose address is already word aligned selects no bytes. The block still issues the write with an empty mask and raises a probe-only flag, so that the memory side checks write permission and marks the line as modified.

The outputs are registered and appear one cycle after the request. A new request may be made on every cycle.

Top module: `stbl_gen`

## Requirements
- R1: In begin mode (req_mode = 0) at word offset 0, wr_be = 4'b1111 and wr_data equals the whole source word.
- R2: In begin mode at offset 1, wr_be = 4'b0111 and wr_data[23:0] = req_data[23:0]. All three bytes go out in the same single write beat.
- R3: In begin mode at offset 2, wr_be = 4'b0011 with wr_data[15:0] = req_data[15:0]. At offset 3, wr_be = 4'b0001 with wr_data[7:0] = req_data[7:0]. Every begin-mode write enables byte-enable bit 0.
- R4: In end mode (req_mode = 1) at offset 1, wr_be = 4'b1000 with wr_data[31:24] = req_data[31:24]. At offset 2, wr_be = 4'b1100 with wr_data[31:16] = req_data[31:16].
- R5: In end mode at offset 3, wr_be = 4'b1110 and wr_data[31:8] = req_data[31:8], in one beat. Every end-mode write at a nonzero offset enables byte-enable bit 3.
- R6: In end mode at offset 0, wr_be = 4'b0000 and wr_probe_only = 1 together with wr_valid. wr_probe_only is 0 for every other request.
- R7: wr_addr equals req_addr with bits 1:0 cleared. In end mode this is also the word that holds the bytes just below the address.
- R8: The lanes are big-endian: byte-enable bit 3 and data bits 31:24 belong to word offset 0, and bit 0 and bits 7:0 belong to offset 3. Any lane whose enable is 0 carries zero data.
- R9: wr_valid is high for exactly one cycle, one clock after each cycle in which req_valid is high. It stays low otherwise, including on back-to-back requests with idle cycles between them.
- R10: While reset is active and until the first request, wr_valid, wr_probe_only and wr_be are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe, one request per cycle high |
| req_mode | input | 1 | 0 = begin mode (low source bytes), 1 = end mode (high source bytes) |
| req_addr | input | 32 | Byte address of the request |
| req_data | input | 32 | Source value |
| wr_valid | output | 1 | Write beat valid, one cycle per request |
| wr_addr | output | 32 | Word-aligned write address |
| wr_be | output | 4 | Byte enables, bit 3 = offset 0 |
| wr_data | output | 32 | Lane-placed write data, bits 31:24 = offset 0 |
| wr_probe_only | output | 1 | Empty write that only asks for a permission check and dirty marking |

## Verification
A wrong lane decode shows as a wrong wr_be on the beat that follows the request, one clock later. Because disabled lanes carry zeros, a shifted or misplaced byte also shows in wr_data on that same beat. A stuck or lost output register shows as a missing or duplicated wr_valid pulse, or as a probe-only flag left set on the next request. The directed tests check every mode and offset pair, high addresses, and back-to-back requests, so each of these faults appears within one or two cycles of the request that triggers it.

// File: rtl/stbl_pkg.sv
package stbl_pkg;
  // Which end of the source word is stored.
  typedef enum logic {
    MODE_BEGIN = 1'b0,  // low-order bytes from the addressed byte onward
    MODE_END   = 1'b1   // high-order bytes into the bytes before the address
  } stb_mode_e;
endpackage

// File: rtl/stbl_rst_sync.sv
module stbl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/stbl_lane_sel.sv
module stbl_lane_sel
  import stbl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  stb_mode_e        mode,
  input  logic [OFF_W-1:0] offset,
  output logic [LANES-1:0] lane_en,
  output logic             probe
);
  // Lane k is word offset k; its enable sits at bit LANES-1-k (big-endian).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (mode == MODE_BEGIN) begin
        lane_en[LANES-1-k] = (OFF_W'(k) >= offset);
      end else begin
        lane_en[LANES-1-k] = (OFF_W'(k) < offset);
      end
    end
  end

  always_comb begin
    probe = (mode == MODE_END) && (offset == '0);
  end
endmodule

// File: rtl/stbl_lane_mask.sv
module stbl_lane_mask #(
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    src,
  input  logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    lanes
);
  // The lane a byte lands on is its own position in the source word, so
  // placing data only needs the disabled lanes cleared.
  for (genvar b = 0; b < LANES; b++) begin : g_byte
    assign lanes[b*8 +: 8] = lane_en[b] ? src[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/stbl_out_stage.sv
module stbl_out_stage #(
  parameter int AW = 32,
  parameter int LANES = 4,
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_addr,
  input  logic [LANES-1:0] in_be,
  input  logic [DW-1:0]    in_data,
  input  logic             in_probe,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic [LANES-1:0] out_be,
  output logic [DW-1:0]    out_data,
  output logic             out_probe
);
  logic             valid_q, valid_d;
  logic [AW-1:0]    addr_q,  addr_d;
  logic [LANES-1:0] be_q,    be_d;
  logic [DW-1:0]    data_q,  data_d;
  logic             probe_q, probe_d;
  logic             load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    addr_d  = addr_q;
    be_d    = be_q;
    data_d  = data_q;
    probe_d = probe_q;
    if (load_en) begin
      addr_d  = in_addr;
      be_d    = in_be;
      data_d  = in_data;
      probe_d = in_probe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
      probe_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      be_q    <= be_d;
      data_q  <= data_d;
      probe_q <= probe_d;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;
  assign out_be    = be_q;
  assign out_data  = data_q;
  assign out_probe = probe_q & valid_q;
endmodule

// File: rtl/stbl_gen.sv
module stbl_gen
  import stbl_pkg::*;
#(
  parameter int AW = 32,
  parameter int LANES = 4,
  localparam int DW = LANES * 8,
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mode,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_be,
  output logic [DW-1:0]    wr_data,
  output logic             wr_probe_only
);
  logic             rst_sync_n;
  stb_mode_e        mode;
  logic [OFF_W-1:0] offset;
  logic [LANES-1:0] lane_en;
  logic             probe;
  logic [DW-1:0]    lanes;
  logic [AW-1:0]    word_addr;

  assign mode   = stb_mode_e'(req_mode);
  assign offset = req_addr[OFF_W-1:0];

  // In end mode the bytes lie below the address, but still in the same word,
  // so clearing the offset bits gives the right word in both modes.
  assign word_addr = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

  stbl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stbl_lane_sel #(.LANES(LANES)) u_lane_sel (
    .mode    (mode),
    .offset  (offset),
    .lane_en (lane_en),
    .probe   (probe)
  );

  stbl_lane_mask #(.LANES(LANES)) u_lane_mask (
    .src     (req_data),
    .lane_en (lane_en),
    .lanes   (lanes)
  );

  stbl_out_stage #(.AW(AW), .LANES(LANES)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (req_valid),
    .in_addr   (word_addr),
    .in_be     (lane_en),
    .in_data   (lanes),
    .in_probe  (probe),
    .out_valid (wr_valid),
    .out_addr  (wr_addr),
    .out_be    (wr_be),
    .out_data  (wr_data),
    .out_probe (wr_probe_only)
  );
endmodule

// File: rtl/stbl_gen_chk.sv
module stbl_gen_chk #(
  parameter int AW = 32,
  parameter int LANES = 4,
  localparam int DW = LANES * 8,
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_mode,
  input logic [AW-1:0]    req_addr,
  input logic             wr_valid,
  input logic [AW-1:0]    wr_addr,
  input logic [LANES-1:0] wr_be,
  input logic [DW-1:0]    wr_data,
  input logic             wr_probe_only
);
  p_valid_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> wr_valid);

  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wr_valid);

  p_word_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (wr_addr[AW-1:OFF_W] == $past(req_addr[AW-1:OFF_W]))
                  && (wr_addr[OFF_W-1:0] == '0));

  p_probe_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_probe_only |-> (wr_valid && (wr_be == '0)));

  p_end_aligned_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode && (req_addr[OFF_W-1:0] == '0)) |=> wr_probe_only);

  p_begin_last_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode) |=> (wr_be[0] && !wr_probe_only));

  p_end_first_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode && (req_addr[OFF_W-1:0] != '0))
      |=> (wr_be[LANES-1] && !wr_probe_only));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    p_idle_lane_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_be[i] |-> (wr_data[i*8 +: 8] == 8'h00));
  end
endmodule

bind stbl_gen stbl_gen_chk #(.AW(AW), .LANES(LANES)) u_stbl_gen_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_mode      (req_mode),
  .req_addr      (req_addr),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .wr_be         (wr_be),
  .wr_data       (wr_data),
  .wr_probe_only (wr_probe_only)
);

// File: tb/test_stbl_gen.sv
module test_stbl_gen;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_mode;
  logic [31:0] req_addr;
  logic [31:0] req_data;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        wr_probe_only;

  int total = 0;
  int bad = 0;

  stbl_gen i_stbl_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_mode      (req_mode),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_be         (wr_be),
    .wr_data       (wr_data),
    .wr_probe_only (wr_probe_only)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Expected byte enables taken from the requirement table (bit 3 = offset 0).
  function automatic logic [3:0] exp_be(input logic mode, input logic [1:0] off);
    if (!mode) begin
      case (off)
        2'd0: return 4'b1111;
        2'd1: return 4'b0111;
        2'd2: return 4'b0011;
        default: return 4'b0001;
      endcase
    end else begin
      case (off)
        2'd0: return 4'b0000;
        2'd1: return 4'b1000;
        2'd2: return 4'b1100;
        default: return 4'b1110;
      endcase
    end
  endfunction

  function automatic logic [31:0] exp_data(input logic [3:0] be, input logic [31:0] src);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return src & m;
  endfunction

  function automatic string rtag(input logic mode, input logic [1:0] off);
    if (!mode) begin
      case (off)
        2'd0: return "R1";
        2'd1: return "R2";
        default: return "R3";
      endcase
    end else begin
      case (off)
        2'd0: return "R6";
        2'd3: return "R5";
        default: return "R4";
      endcase
    end
  endfunction

  task automatic drive(input logic mode, input logic [31:0] addr, input logic [31:0] src);
    req_valid = 1'b1;
    req_mode  = mode;
    req_addr  = addr;
    req_data  = src;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_mode  = 1'b0;
    req_addr  = 32'h0;
    req_data  = 32'h0;
  endtask

  task automatic check_beat(input logic mode, input logic [31:0] addr, input logic [31:0] src);
    logic [3:0] be;
    string t;
    be = exp_be(mode, addr[1:0]);
    t = rtag(mode, addr[1:0]);
    chk({t, " R9 valid"}, {31'd0, wr_valid}, 32'd1);
    chk({t, " be"}, {28'd0, wr_be}, {28'd0, be});
    chk({t, " R8 data"}, wr_data, exp_data(be, src));
    chk({"R6 probe ", t}, {31'd0, wr_probe_only}, {31'd0, (mode && addr[1:0] == 2'd0)});
    chk("R7 addr", wr_addr, {addr[31:2], 2'b00});
  endtask

  task automatic one_req(input logic mode, input logic [31:0] addr, input logic [31:0] src);
    drive(mode, addr, src);
    @(negedge clk);
    idle();
    check_beat(mode, addr, src);
    @(negedge clk);
    chk("R9 single pulse", {31'd0, wr_valid}, 32'd0);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", {31'd0, wr_valid}, 32'd0);
    chk("R10 be in reset", {28'd0, wr_be}, 32'd0);
    chk("R10 probe in reset", {31'd0, wr_probe_only}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset", {31'd0, wr_valid}, 32'd0);
    chk("R10 probe after reset", {31'd0, wr_probe_only}, 32'd0);
  endtask

  task automatic t_begin_modes();
    for (int off = 0; off < 4; off++)
      one_req(1'b0, 32'h0000_1230 | off, 32'hA1B2_C3D4);
    one_req(1'b0, 32'h8000_0041, 32'h0F1E_2D3C);  // R2 three-byte, other data
  endtask

  task automatic t_end_modes();
    for (int off = 0; off < 4; off++)
      one_req(1'b1, 32'h0000_4564 | off, 32'h1122_3344);
    one_req(1'b1, 32'h7FFF_FFF7, 32'hDEAD_BEEF);  // R5 three-byte, other data
  endtask

  task automatic t_high_addr();
    one_req(1'b0, 32'hFFFF_FFFF, 32'h5566_7788);  // R7 top of space, begin off 3
    one_req(1'b1, 32'hFFFF_FFFC, 32'h99AA_BBCC);  // R6 probe at top word
  endtask

  task automatic t_back_to_back();
    drive(1'b1, 32'h0000_2000, 32'hCAFE_F00D);   // R6 probe beat
    @(negedge clk);
    check_beat(1'b1, 32'h0000_2000, 32'hCAFE_F00D);
    drive(1'b0, 32'h0000_2002, 32'h0123_4567);   // R3 right after probe
    @(negedge clk);
    check_beat(1'b0, 32'h0000_2002, 32'h0123_4567);
    drive(1'b1, 32'h0000_3003, 32'h89AB_CDEF);   // R5 third in a row
    @(negedge clk);
    idle();
    check_beat(1'b1, 32'h0000_3003, 32'h89AB_CDEF);
    @(negedge clk);
    chk("R9 idle after burst", {31'd0, wr_valid}, 32'd0);
    @(negedge clk);
    chk("R9 still idle", {31'd0, wr_valid}, 32'd0);
    chk("R6 probe clear when idle", {31'd0, wr_probe_only}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_begin_modes();
    t_end_modes();
    t_high_addr();
    t_back_to_back();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule